// File: doc/BRIEF.md
# Age-Ordered Issue Selector With Per-Class and Total Caps

This block keeps a small pool of instruction-queue slots. Each slot records whether it is occupied, whether its operands are available, a 16-bit age tag and a functional class. In every cycle it grants a set of slots for issue. Within one class the oldest ready slots go first. The number of grants per class is bounded by that class's own width, and the sum over all classes is bounded by a global width.

Slots are addressed by index. An upstream allocator writes one slot per cycle through the insert port, and it may only pick a slot that is free. A wakeup mask marks slots as ready. A flush names an age tag and removes every slot younger than it. The grant vector is combinational from the stored state and the flush inputs. A granted slot is released on the same clock edge, so the allocator can reuse it on the next cycle. The free-slot count and a full flag let the allocator throttle.

Top module: `iq_issue_select`

## Requirements
- R1: After reset no slot is occupied, `grant_vec` is zero, `free_count` equals the slot count and `full` is low.
- R2: An insert writes the slot at `ins_idx` with its age tag, class and ready bit from the next cycle on. `free_count` counts unoccupied slots, and `full` is high exactly when it is zero.
- R3: A bit of `wake_mask` makes the matching occupied slot ready from the next cycle on. Only slots that are occupied and ready are ever granted.
- R4: Within a class, slots are granted in age order. Tag a is older than tag b when bit 15 of (a - b) mod 2^16 is set. Equal tags fall back to the lower index.
- R5: Per cycle, at most `INT_W` integer (code 0), `FP_W` float (code 1), `BR_W` branch (code 2), `MEM_W` memory (code 3) and `MISC_W` misc (code 4) slots are granted. Codes 5 to 7 count as misc.
- R6: At most `TOTAL_W` slots are granted per cycle. Classes take the remaining slots in the fixed order integer, float, branch, memory, misc.
- R7: A granted slot is unoccupied from the next cycle on and can be written again in that cycle.
- R8: With `squash_valid` high, every slot whose tag is strictly younger than `squash_seq` is not granted in that cycle and is unoccupied from the next one. Slots with an equal or older tag are untouched.
- R9: An insert in the same cycle as a flush is dropped when its tag is strictly younger than `squash_seq`. Otherwise it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Write a slot this cycle |
| ins_idx | input | IDX_W | Slot index to write |
| ins_seq | input | SEQ_W | Age tag of the new entry |
| ins_class | input | 3 | Functional class code |
| ins_ready | input | 1 | New entry is ready at once |
| wake_mask | input | N_ENTRIES | Mark slots ready |
| squash_valid | input | 1 | Flush request |
| squash_seq | input | SEQ_W | Flush point; younger tags are removed |
| grant_vec | output | N_ENTRIES | Slots issued this cycle |
| free_count | output | CNT_W | Number of unoccupied slots |
| full | output | 1 | No slot free |

## Verification
Age tags that straddle the 16-bit wrap tell wrap-aware ordering apart from a plain unsigned compare. A full pool of ready integer entries tells the per-class cap apart from the global cap. A mixed-class pool shows that the fixed class order decides who gets the remaining global slots. The random phase mixes inserts, unknown class codes, wakeups and flushes, including inserts on both sides of the flush point. It also reuses slots right after grant, which separates correct release and drop rules from off-by-one tag compares.

// File: rtl/iq_sel_pkg.sv
package iq_sel_pkg;
   localparam int NUM_CLASSES = 5;

   typedef enum logic [2:0] {
      CL_INT  = 3'd0,
      CL_FP   = 3'd1,
      CL_BR   = 3'd2,
      CL_MEM  = 3'd3,
      CL_MISC = 3'd4
   } iq_class_e;

   // unknown codes fold onto the misc pool
   function automatic logic [2:0] fold_class(input logic [2:0] code);
      return (code > 3'd4) ? 3'(CL_MISC) : code;
   endfunction
endpackage

// File: rtl/iq_entry_store.sv
module iq_entry_store #(
   parameter int N_ENTRIES = 8,
   parameter int SEQ_W     = 16,
   localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             ins_valid,
   input  logic [IDX_W-1:0]                 ins_idx,
   input  logic [SEQ_W-1:0]                 ins_seq,
   input  logic [2:0]                       ins_class,
   input  logic                             ins_ready,
   input  logic [N_ENTRIES-1:0]             wake_mask,
   input  logic                             squash_valid,
   input  logic [SEQ_W-1:0]                 squash_seq,
   input  logic [N_ENTRIES-1:0]             grant,
   output logic [N_ENTRIES-1:0]             ent_valid,
   output logic [N_ENTRIES-1:0]             ent_ready,
   output logic [N_ENTRIES-1:0][SEQ_W-1:0]  ent_seq,
   output logic [N_ENTRIES-1:0][2:0]        ent_cls,
   output logic [N_ENTRIES-1:0]             kill_sq
);
   import iq_sel_pkg::*;

   logic [SEQ_W-1:0] ins_diff;
   logic             ins_keep;

   assign ins_diff = ins_seq - squash_seq;
   assign ins_keep = !(squash_valid && !ins_diff[SEQ_W-1] && (ins_diff != '0));

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
      logic [SEQ_W-1:0] sq_diff;
      logic             hit;

      assign sq_diff    = ent_seq[i] - squash_seq;
      assign kill_sq[i] = squash_valid && ent_valid[i] && !sq_diff[SEQ_W-1] && (sq_diff != '0);
      assign hit        = ins_valid && (ins_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_valid[i] <= 1'b0;
            ent_ready[i] <= 1'b0;
            ent_seq[i]   <= '0;
            ent_cls[i]   <= '0;
         end else if (hit && ins_keep) begin
            ent_valid[i] <= 1'b1;
            ent_ready[i] <= ins_ready;
            ent_seq[i]   <= ins_seq;
            ent_cls[i]   <= fold_class(ins_class);
         end else if (grant[i] || kill_sq[i]) begin
            ent_valid[i] <= 1'b0;
            ent_ready[i] <= 1'b0;
         end else if (wake_mask[i] && ent_valid[i]) begin
            ent_ready[i] <= 1'b1;
         end
      end

      AST_GRANT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
         grant[i] && !hit |=> !ent_valid[i]) else $error("grant did not release slot"); // R7
      AST_FLUSH_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
         kill_sq[i] && !hit |=> !ent_valid[i]) else $error("flush left slot"); // R8
      AST_FLUSH_DROPS_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
         hit && !ins_keep && !ent_valid[i] |=> !ent_valid[i]) else $error("young insert kept"); // R9
   end
endmodule

// File: rtl/iq_age_rank.sv
module iq_age_rank #(
   parameter int N_ENTRIES = 8,
   parameter int SEQ_W     = 16,
   localparam int CNT_W    = $clog2(N_ENTRIES + 1)
) (
   input  logic [N_ENTRIES-1:0]             elig,
   input  logic [N_ENTRIES-1:0][SEQ_W-1:0]  ent_seq,
   input  logic [N_ENTRIES-1:0][2:0]        ent_cls,
   output logic [N_ENTRIES-1:0][CNT_W-1:0]  rank
);
   // rank = number of eligible same-class slots that must go before this one
   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_rank
      always_comb begin
         logic [SEQ_W-1:0] d;
         rank[i] = '0;
         for (int j = 0; j < N_ENTRIES; j++) begin
            d = ent_seq[j] - ent_seq[i];
            if (j != i && elig[j] && ent_cls[j] == ent_cls[i] &&
                (d[SEQ_W-1] || (d == '0 && j < i)))
               rank[i] = rank[i] + 1'b1;
         end
      end
   end
endmodule

// File: rtl/iq_class_cap.sv
module iq_class_cap #(
   parameter int N_ENTRIES = 8,
   parameter int INT_W     = 2,
   parameter int FP_W      = 1,
   parameter int BR_W      = 1,
   parameter int MEM_W     = 1,
   parameter int MISC_W    = 1,
   parameter int TOTAL_W   = 3,
   localparam int CNT_W    = $clog2(N_ENTRIES + 1)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [N_ENTRIES-1:0]             elig,
   input  logic [N_ENTRIES-1:0][2:0]        ent_cls,
   input  logic [N_ENTRIES-1:0][CNT_W-1:0]  rank,
   output logic [N_ENTRIES-1:0]             grant
);
   import iq_sel_pkg::*;

   localparam int CW [NUM_CLASSES] = '{INT_W, FP_W, BR_W, MEM_W, MISC_W};

   int take [8];

   // classes claim the global budget in fixed order
   always_comb begin
      int rem;
      int cnt;
      rem = TOTAL_W;
      for (int k = 0; k < 8; k++) take[k] = 0;
      for (int c = 0; c < NUM_CLASSES; c++) begin
         cnt = 0;
         for (int i = 0; i < N_ENTRIES; i++)
            if (elig[i] && int'(ent_cls[i]) == c) cnt++;
         if (cnt > CW[c]) cnt = CW[c];
         if (cnt > rem)   cnt = rem;
         take[c] = cnt;
         rem     = rem - cnt;
      end
   end

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_grant
      assign grant[i] = elig[i] && (int'(rank[i]) < take[ent_cls[i]]);
   end

   for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cap_chk
      logic [N_ENTRIES-1:0] in_cls;
      for (genvar i = 0; i < N_ENTRIES; i++) begin : g_m
         assign in_cls[i] = (int'(ent_cls[i]) == c);
      end
      AST_CLASS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(grant & in_cls) <= CW[c]) else $error("class cap exceeded"); // R5
   end

   AST_TOTAL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant) <= TOTAL_W) else $error("total cap exceeded"); // R6
endmodule

// File: rtl/iq_issue_select.sv
module iq_issue_select #(
   parameter int N_ENTRIES = 8,
   parameter int SEQ_W     = 16,
   parameter int INT_W     = 2,
   parameter int FP_W      = 1,
   parameter int BR_W      = 1,
   parameter int MEM_W     = 1,
   parameter int MISC_W    = 1,
   parameter int TOTAL_W   = 3,
   localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
   localparam int CNT_W    = $clog2(N_ENTRIES + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ins_valid,
   input  logic [IDX_W-1:0]      ins_idx,
   input  logic [SEQ_W-1:0]      ins_seq,
   input  logic [2:0]            ins_class,
   input  logic                  ins_ready,
   input  logic [N_ENTRIES-1:0]  wake_mask,
   input  logic                  squash_valid,
   input  logic [SEQ_W-1:0]      squash_seq,
   output logic [N_ENTRIES-1:0]  grant_vec,
   output logic [CNT_W-1:0]      free_count,
   output logic                  full
);
   if (N_ENTRIES < 2 || N_ENTRIES > 64) begin : g_bad_depth
      $error("N_ENTRIES must lie in 2..64");
   end
   if (SEQ_W < 2) begin : g_bad_seq
      $error("SEQ_W must be at least 2");
   end
   if (TOTAL_W < 1 || TOTAL_W > N_ENTRIES) begin : g_bad_total
      $error("TOTAL_W must lie in 1..N_ENTRIES");
   end
   if (INT_W < 1 || FP_W < 1 || BR_W < 1 || MEM_W < 1 || MISC_W < 1) begin : g_bad_cls
      $error("every class width must be at least 1");
   end

   logic [N_ENTRIES-1:0]             ent_valid, ent_ready, kill_sq, elig;
   logic [N_ENTRIES-1:0][SEQ_W-1:0]  ent_seq;
   logic [N_ENTRIES-1:0][2:0]        ent_cls;
   logic [N_ENTRIES-1:0][CNT_W-1:0]  rank;

   iq_entry_store #(.N_ENTRIES(N_ENTRIES), .SEQ_W(SEQ_W)) u_store (
      .clk, .rst_n, .ins_valid, .ins_idx, .ins_seq, .ins_class, .ins_ready,
      .wake_mask, .squash_valid, .squash_seq, .grant(grant_vec),
      .ent_valid, .ent_ready, .ent_seq, .ent_cls, .kill_sq
   );

   assign elig = ent_valid & ent_ready & ~kill_sq;

   iq_age_rank #(.N_ENTRIES(N_ENTRIES), .SEQ_W(SEQ_W)) u_rank (
      .elig, .ent_seq, .ent_cls, .rank
   );

   iq_class_cap #(
      .N_ENTRIES(N_ENTRIES), .INT_W(INT_W), .FP_W(FP_W), .BR_W(BR_W),
      .MEM_W(MEM_W), .MISC_W(MISC_W), .TOTAL_W(TOTAL_W)
   ) u_cap (
      .clk, .rst_n, .elig, .ent_cls, .rank, .grant(grant_vec)
   );

   always_comb begin
      free_count = CNT_W'(N_ENTRIES);
      for (int i = 0; i < N_ENTRIES; i++)
         if (ent_valid[i]) free_count = free_count - 1'b1;
   end
   assign full = (free_count == '0);

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_chk
      AST_GRANT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
         grant_vec[i] |-> (ent_valid[i] && ent_ready[i])) else $error("granted unready slot"); // R3
   end
endmodule

// File: tb/iq_issue_select_bench.sv
module iq_issue_select_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N   = 8;
   localparam int TOT = 3;
   localparam int CW [5] = '{2, 1, 1, 1, 1};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ins_valid = 1'b0;
   logic [2:0]  ins_idx = '0;
   logic [15:0] ins_seq = '0;
   logic [2:0]  ins_class = '0;
   logic        ins_ready = 1'b0;
   logic [N-1:0] wake_mask = '0;
   logic        squash_valid = 1'b0;
   logic [15:0] squash_seq = '0;
   logic [N-1:0] grant_vec;
   logic [3:0]  free_count;
   logic        full;

   int checks = 0, fails = 0;
   bit done = 0;

   logic        m_valid [N];
   logic        m_ready [N];
   logic [15:0] m_seq   [N];
   logic [2:0]  m_cls   [N];
   logic [15:0] nseq;

   iq_issue_select #(.N_ENTRIES(N), .SEQ_W(16), .INT_W(2), .FP_W(1), .BR_W(1),
                     .MEM_W(1), .MISC_W(1), .TOTAL_W(TOT)) u_iq_issue_select (
      .clk, .rst_n, .ins_valid, .ins_idx, .ins_seq, .ins_class, .ins_ready,
      .wake_mask, .squash_valid, .squash_seq, .grant_vec, .free_count, .full
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic bit is_older(input logic [15:0] a, input logic [15:0] b);
      logic [15:0] d = a - b;
      return d[15];
   endfunction

   function automatic bit is_younger(input logic [15:0] a, input logic [15:0] b);
      return is_older(b, a);
   endfunction

   function automatic logic [N-1:0] calc_grant();
      logic [N-1:0] picked = '0;
      int used = 0;
      for (int c = 0; c < 5; c++) begin
         int lim = CW[c];
         if (TOT - used < lim) lim = TOT - used;
         for (int k = 0; k < lim; k++) begin
            int best = -1;
            for (int i = 0; i < N; i++) begin
               if (m_valid[i] && m_ready[i] && int'(m_cls[i]) == c && !picked[i] &&
                   !(squash_valid && is_younger(m_seq[i], squash_seq)))
                  if (best < 0 || is_older(m_seq[i], m_seq[best])) best = i;
            end
            if (best >= 0) begin
               picked[best] = 1'b1;
               used++;
            end
         end
      end
      return picked;
   endfunction

   function automatic int model_free();
      int f = 0;
      for (int i = 0; i < N; i++) if (!m_valid[i]) f++;
      return f;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < N; i++) begin
         m_valid[i] = 0; m_ready[i] = 0; m_seq[i] = '0; m_cls[i] = '0;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      model_clear();
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic idle_inputs();
      ins_valid = 0; ins_ready = 0; wake_mask = '0; squash_valid = 0;
   endtask

   // inputs already driven after a falling edge; check, clock, update model
   task automatic step(input string tag);
      logic [N-1:0] eg;
      #1;
      eg = calc_grant();
      check({tag, " grant"}, 32'(grant_vec), 32'(eg));
      check("R2 R7 free_count", 32'(free_count), 32'(model_free()));
      check("R2 full", 32'(full), 32'(model_free() == 0));
      @(posedge clk);
      for (int i = 0; i < N; i++) begin
         bool_upd(i, eg[i]);
      end
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic bool_upd(input int i, input bit g);
      bit hit = ins_valid && int'(ins_idx) == i;
      bit keep = !(squash_valid && is_younger(ins_seq, squash_seq));
      bit sq = squash_valid && m_valid[i] && is_younger(m_seq[i], squash_seq);
      if (hit && keep) begin
         m_valid[i] = 1; m_ready[i] = ins_ready; m_seq[i] = ins_seq;
         m_cls[i] = (ins_class > 3'd4) ? 3'd4 : ins_class;
      end else if (g || sq) begin
         m_valid[i] = 0; m_ready[i] = 0;
      end else if (wake_mask[i] && m_valid[i]) begin
         m_ready[i] = 1;
      end
   endtask

   task automatic put(input int idx, input logic [15:0] s, input logic [2:0] c, input bit rdy);
      ins_valid = 1; ins_idx = 3'(idx); ins_seq = s; ins_class = c; ins_ready = rdy;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7741));
      do_reset();

      // R1: reset state
      #1;
      check("R1 grant", 32'(grant_vec), 0);
      check("R1 free_count", 32'(free_count), N);
      check("R1 full", 32'(full), 0);
      step("R1");

      // R2 R4 R5: eight unready integer slots straddling the tag wrap, then wake all
      for (int i = 0; i < N; i++) begin
         put(i, 16'h0003 - 16'(i), 3'd0, 1'b0);
         step("R2");
      end
      wake_mask = '1;
      step("R3");
      repeat (4) step("R4 R5");

      // R6: mixed classes, all ready at once, fixed class order decides
      do_reset();
      for (int i = 0; i < N; i++) begin
         put(i, 16'h0100 + 16'(N - i), 3'(i % 6), 1'b0);
         step("R2 R5");
      end
      wake_mask = '1;
      step("R3");
      repeat (4) step("R6");

      // R8 R9: flush removes younger slots; insert on each side of the point
      do_reset();
      for (int i = 0; i < 6; i++) begin
         put(i, 16'hFFFE + 16'(i), 3'd1, 1'b0);
         step("R2");
      end
      squash_valid = 1; squash_seq = 16'h0000;
      wake_mask = '1;
      put(6, 16'h0001, 3'd2, 1'b1);
      step("R8 R9");
      squash_valid = 1; squash_seq = 16'hFFFF;
      put(7, 16'hFFFF, 3'd3, 1'b1);
      step("R8 R9");
      repeat (3) step("R8");

      // random phase
      do_reset();
      nseq = 16'hFF80;
      for (int cyc = 0; cyc < 4000; cyc++) begin
         int fi = -1;
         for (int i = 0; i < N; i++) if (!m_valid[i] && ($urandom % 3 != 0 || fi < 0)) fi = i;
         if (fi >= 0 && ($urandom % 4 != 0)) begin
            logic [15:0] s = ($urandom % 8 == 0) ? nseq - 16'd12 : nseq;
            put(fi, s, 3'($urandom % 8), 1'($urandom % 2));
            nseq = nseq + 1'b1;
         end
         if ($urandom % 3 == 0) wake_mask = N'($urandom);
         if ($urandom % 16 == 0) begin
            squash_valid = 1;
            squash_seq = nseq - 16'($urandom % 6) - 16'd1;
         end
         step("R3 R4 R5 R6 R7 R8 R9");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule